// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block turns a single register-access request into the full chain of bus operations that an I2C master needs, and hands those operations one at a time to a byte-level I2C engine. The requester supplies a 7-bit device address, a register address, a byte count and a direction, then pulses a start strobe. From then on the sequencer issues one command per stage and moves to the next stage only when the engine reports completion. The requester does not take part in any single byte.

Two message shapes are produced. A register write sends the device address with the write bit, then the register address, then the data bytes taken from the requester's buffer, then stop. A combined register read first sets the register pointer with a write-addressed phase. It then issues a repeated start and the device address with the read bit, and arms the receiver once. The byte from that arming step is thrown away. After that it collects the data bytes, answering each with ACK except the final one, which gets NACK, and it finishes with stop. Received bytes are written back through the same buffer port.

Before launching, the sequencer waits for the bus to be free and reports a busy code while it waits. If the bus stays busy for the whole timeout window, it reports a timeout and asks for bus recovery. After recovery it waits once more. A second timeout ends the request with a permanent-fault code.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset the sequencer is idle: `in_prog`, `cmd_valid`, `recover_req`, `xact_done` and `buf_we` are low and `fault` is 0 (no fault).
- R2: A write request with count N>0 on a free bus issues, in order: START (op 0), WRITE (op 2) of the byte {dev,0}, WRITE of the register address, N WRITEs of buffer bytes at indexes 0..N-1, and STOP (op 6). It completes with fault code 0.
- R3: A write request with count 0 issues START, the {dev,0} WRITE, the register WRITE and then STOP, with no data bytes.
- R4: A read request with count N issues START, WRITE {dev,0}, WRITE register, RSTART (op 1), WRITE {dev,1}, one RX_ARM (op 3), N-1 READ_ACK (op 4), one READ_NACK (op 5) and STOP.
- R5: The byte returned by RX_ARM is discarded. Each READ_ACK/READ_NACK result is written through `buf_we`/`buf_rdata` at indexes 0..N-1 in arrival order. `buf_we` pulses only on the completion of such a read.
- R6: A read request with count 0 is carried out as a one-byte read: RX_ARM is followed directly by READ_NACK.
- R7: At most one command is outstanding. `cmd_valid` is a one-cycle pulse, and the next pulse comes only after the engine has strobed `cmd_done` for the previous one.
- R8: `in_prog` rises when a message is launched and falls in the same cycle as the one-cycle `xact_done` pulse, after the STOP completion. Start strobes given while a request is being handled are ignored.
- R9: A request made while `bus_busy` is high sets `fault` to 1 (bus busy) and issues no command until `bus_busy` is low. The message then launches normally, and `in_prog` only rises after a cycle with the bus free.
- R10: If `bus_busy` stays high for TIMEOUT_CYC cycles of waiting, `fault` becomes 2 (timeout) and `recover_req` is held high until `recover_done`. The sequencer then waits for the bus again. A retried message that then completes keeps code 2.
- R11: A second timeout for the same request sets `fault` to 3 (permanent bus fault). It pulses `xact_done` and returns to idle without issuing any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = combined register read, 0 = register write |
| req_dev | input | 7 | 7-bit device address |
| req_reg | input | 8 | Register address |
| req_len | input | LEN_W | Number of data bytes |
| buf_idx | output | LEN_W | Current index into the requester's data buffer |
| buf_wdata | input | 8 | Buffer byte at `buf_idx`, used for writes |
| buf_we | output | 1 | Strobe storing `buf_rdata` at `buf_idx` |
| buf_rdata | output | 8 | Received data byte |
| cmd_valid | output | 1 | One-cycle command pulse to the byte engine |
| cmd_op | output | 3 | Command code (0 START, 1 RSTART, 2 WRITE, 3 RX_ARM, 4 READ_ACK, 5 READ_NACK, 6 STOP) |
| cmd_byte | output | 8 | Byte to send with a WRITE command |
| cmd_done | input | 1 | Engine completion strobe for the outstanding command |
| cmd_rx | input | 8 | Byte received by the completed read command |
| bus_busy | input | 1 | Bus busy: set by a start, cleared by a stop |
| recover_req | output | 1 | Request for bus recovery, held until acknowledged |
| recover_done | input | 1 | Bus recovery finished |
| in_prog | output | 1 | A message is on the bus |
| xact_done | output | 1 | One-cycle pulse when a request ends |
| fault | output | 2 | Result code: 0 none, 1 busy, 2 timeout, 3 permanent |

## Verification
The checker watches the engine handshake on every cycle. It confirms that a command never overlaps an outstanding one, that no command appears while no message is in progress or while recovery is requested, and that the data strobe appears only on an engine completion. It also checks that the end of a message always coincides with the done pulse, that a launch only follows a free bus, that the recovery request is held until acknowledged, and that a permanent fault always lands in idle with the done pulse. The exact order and content of the command chains, the discarding of the dummy byte, the buffer indexes and the length of the timeout window can only be shown by the bench's scenarios. Each scenario runs a behavioural engine and register-file slave.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_BUS,
    ST_RECOVER,
    ST_START,
    ST_DEV_ADDR_W,
    ST_REG_ADDR,
    ST_RSTART,
    ST_DEV_ADDR_R,
    ST_DUMMY,
    ST_READ_DATA,
    ST_NACK_LAST,
    ST_WRITE_DATA,
    ST_STOP
  } stage_t;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_RSTART    = 3'd1,
    OP_WRITE     = 3'd2,
    OP_RX_ARM    = 3'd3,
    OP_READ_ACK  = 3'd4,
    OP_READ_NACK = 3'd5,
    OP_STOP      = 3'd6
  } bus_op_t;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_BUSY      = 2'd1,
    FLT_TIMEOUT   = 2'd2,
    FLT_PERMANENT = 2'd3
  } fault_t;

  // Address byte: 7-bit device address in the upper bits, direction in bit 0.
  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

  // Stage that follows a completed bus command.
  function automatic stage_t stage_after(input stage_t cur, input logic rd,
                                         input logic len_zero, input logic at_last,
                                         input logic pre_last);
    stage_t n;
    n = ST_IDLE;
    case (cur)
      ST_START:      n = ST_DEV_ADDR_W;
      ST_DEV_ADDR_W: n = ST_REG_ADDR;
      ST_REG_ADDR:   n = rd ? ST_RSTART : (len_zero ? ST_STOP : ST_WRITE_DATA);
      ST_WRITE_DATA: n = at_last ? ST_STOP : ST_WRITE_DATA;
      ST_RSTART:     n = ST_DEV_ADDR_R;
      ST_DEV_ADDR_R: n = ST_DUMMY;
      ST_DUMMY:      n = at_last ? ST_NACK_LAST : ST_READ_DATA;
      ST_READ_DATA:  n = pre_last ? ST_NACK_LAST : ST_READ_DATA;
      ST_NACK_LAST:  n = ST_STOP;
      default:       n = ST_IDLE;
    endcase
    return n;
  endfunction

  // True for stages whose completion delivers a data byte for the buffer.
  function automatic logic stage_stores(input stage_t cur);
    return (cur == ST_READ_DATA) || (cur == ST_NACK_LAST);
  endfunction

endpackage

// File: rtl/i2c_seq_index.sv
module i2c_seq_index #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx,
  output logic             at_last,
  output logic             pre_last
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] last_pos;
  logic [LEN_W-1:0] idx_next;

  assign last_pos = len - ONE;
  assign idx_next = idx + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx_next;
  end

  assign at_last  = (idx == last_pos);
  assign pre_last = (idx_next == last_pos);

endmodule

// File: rtl/i2c_seq_wait_timer.sv
module i2c_seq_wait_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CW'(1);
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/i2c_seq_cmd_map.sv
module i2c_seq_cmd_map
  import i2c_seq_pkg::*;
(
  input  stage_t      stage,
  input  logic [6:0]  dev,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  wdata,
  output logic        issue,
  output bus_op_t     op,
  output logic [7:0]  data_o
);

  always_comb begin
    issue  = 1'b1;
    op     = OP_STOP;
    data_o = 8'h00;
    case (stage)
      ST_START:      op = OP_START;
      ST_DEV_ADDR_W: begin op = OP_WRITE; data_o = addr_byte(dev, 1'b0); end
      ST_REG_ADDR:   begin op = OP_WRITE; data_o = reg_addr; end
      ST_WRITE_DATA: begin op = OP_WRITE; data_o = wdata; end
      ST_RSTART:     op = OP_RSTART;
      ST_DEV_ADDR_R: begin op = OP_WRITE; data_o = addr_byte(dev, 1'b1); end
      ST_DUMMY:      op = OP_RX_ARM;
      ST_READ_DATA:  op = OP_READ_ACK;
      ST_NACK_LAST:  op = OP_READ_NACK;
      ST_STOP:       op = OP_STOP;
      default:       issue = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int CLK_PER_BIT = 2500,
  parameter int TIMEOUT_CYC = 2 * ((1 << LEN_W) + 5) * 9 * CLK_PER_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_read,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_reg,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] buf_idx,
  input  logic [7:0]       buf_wdata,
  output logic             buf_we,
  output logic [7:0]       buf_rdata,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_done,
  input  logic [7:0]       cmd_rx,
  input  logic             bus_busy,
  output logic             recover_req,
  input  logic             recover_done,
  output logic             in_prog,
  output logic             xact_done,
  output logic [1:0]       fault
);

  localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);

  stage_t           stg;
  stage_t           nxt_stg;
  logic             waiting;
  logic             rd_q;
  logic [6:0]       dev_q;
  logic [7:0]       reg_q;
  logic [LEN_W-1:0] len_q;
  logic             retried;
  logic             prog_q;
  logic             done_q;
  fault_t           fault_q;

  // Named internal events.
  logic             cmd_fire;
  logic             step_done;
  logic             launch;
  logic             idx_step;
  logic             len_zero;
  logic             at_last;
  logic             pre_last;
  logic             tmr_expired;
  logic             map_issue;
  bus_op_t          map_op;
  logic [7:0]       map_byte;
  logic [LEN_W-1:0] idx;

  i2c_seq_cmd_map u_map (
    .stage    (stg),
    .dev      (dev_q),
    .reg_addr (reg_q),
    .wdata    (buf_wdata),
    .issue    (map_issue),
    .op       (map_op),
    .data_o   (map_byte)
  );

  i2c_seq_index #(.LEN_W(LEN_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (stg == ST_IDLE),
    .step     (idx_step),
    .len      (len_q),
    .idx      (idx),
    .at_last  (at_last),
    .pre_last (pre_last)
  );

  i2c_seq_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (stg == ST_WAIT_BUS),
    .expired (tmr_expired)
  );

  assign cmd_fire  = map_issue && !waiting;
  assign step_done = waiting && cmd_done;
  assign len_zero  = (len_q == '0);
  assign idx_step  = step_done && ((stg == ST_WRITE_DATA) || (stg == ST_READ_DATA));
  assign launch    = !bus_busy &&
                     (((stg == ST_IDLE) && req_start) || (stg == ST_WAIT_BUS));
  assign nxt_stg   = stage_after(stg, rd_q, len_zero, at_last, pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg     <= ST_IDLE;
      waiting <= 1'b0;
      rd_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      len_q   <= '0;
      retried <= 1'b0;
      prog_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      if (cmd_fire)  waiting <= 1'b1;
      if (step_done) waiting <= 1'b0;
      case (stg)
        ST_IDLE: begin
          if (req_start) begin
            rd_q    <= req_read;
            dev_q   <= req_dev;
            reg_q   <= req_reg;
            len_q   <= (req_read && (req_len == '0)) ? ONE_BYTE : req_len;
            retried <= 1'b0;
            if (launch) begin
              stg     <= ST_START;
              prog_q  <= 1'b1;
              fault_q <= FLT_NONE;
            end else begin
              stg     <= ST_WAIT_BUS;
              fault_q <= FLT_BUSY;
            end
          end
        end
        ST_WAIT_BUS: begin
          if (launch) begin
            stg    <= ST_START;
            prog_q <= 1'b1;
          end else if (tmr_expired) begin
            if (retried) begin
              fault_q <= FLT_PERMANENT;
              stg     <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              fault_q <= FLT_TIMEOUT;
              retried <= 1'b1;
              stg     <= ST_RECOVER;
            end
          end
        end
        ST_RECOVER: begin
          if (recover_done) stg <= ST_WAIT_BUS;
        end
        default: begin
          if (step_done) begin
            stg <= nxt_stg;
            if (stg == ST_STOP) begin
              prog_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign buf_idx     = idx;
  assign buf_we      = step_done && stage_stores(stg);
  assign buf_rdata   = cmd_rx;
  assign cmd_valid   = cmd_fire;
  assign cmd_op      = map_op;
  assign cmd_byte    = map_byte;
  assign recover_req = (stg == ST_RECOVER);
  assign in_prog     = prog_q;
  assign xact_done   = done_q;
  assign fault       = fault_q;

endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_done,
  input logic       buf_we,
  input logic       bus_busy,
  input logic       recover_req,
  input logic       recover_done,
  input logic       in_prog,
  input logic       xact_done,
  input logic [1:0] fault
);

  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outst <= 1'b0;
    else if (cmd_valid) outst <= 1'b1;
    else if (cmd_done)  outst <= 1'b0;
  end

  p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !outst);

  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_prog |-> !cmd_valid);

  p_end_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_prog) |-> xact_done);

  p_launch_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_prog) |-> !$past(bus_busy));

  p_store_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> cmd_done && in_prog);

  p_recover_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req && !recover_done |=> recover_req);

  p_recover_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |-> !in_prog && !cmd_valid);

  p_perm_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault == 2'd3) |-> xact_done && !in_prog);

endmodule

bind i2c_xact_seq i2c_xact_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_done     (cmd_done),
  .buf_we       (buf_we),
  .bus_busy     (bus_busy),
  .recover_req  (recover_req),
  .recover_done (recover_done),
  .in_prog      (in_prog),
  .xact_done    (xact_done),
  .fault        (fault)
);

// File: tb/i2c_xact_seq_tb.sv
`timescale 1ns/1ps
module i2c_xact_seq_tb;

  localparam int LW   = 4;
  localparam int TOUT = 40;
  localparam int ENG_LAT = 3;
  localparam logic [2:0] C_START = 3'd0, C_RSTART = 3'd1, C_WRITE = 3'd2,
                         C_ARM = 3'd3, C_RACK = 3'd4, C_RNACK = 3'd5, C_STOP = 3'd6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0, req_read = 1'b0;
  logic [6:0]    req_dev = '0;
  logic [7:0]    req_reg = '0;
  logic [LW-1:0] req_len = '0;
  logic [LW-1:0] buf_idx;
  logic [7:0]    buf_wdata, buf_rdata, cmd_byte, cmd_rx;
  logic          buf_we, cmd_valid, cmd_done, bus_busy, recover_req;
  logic          recover_done = 1'b0, in_prog, xact_done, force_busy = 1'b0;
  logic [2:0]    cmd_op;
  logic [1:0]    fault;

  always #2 clk = ~clk;

  i2c_xact_seq #(.LEN_W(LW), .TIMEOUT_CYC(TOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
    .req_dev(req_dev), .req_reg(req_reg), .req_len(req_len),
    .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_rdata(buf_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
    .cmd_rx(cmd_rx), .bus_busy(bus_busy), .recover_req(recover_req),
    .recover_done(recover_done), .in_prog(in_prog), .xact_done(xact_done), .fault(fault)
  );

  // Requester buffers.
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  int         we_cnt;
  assign buf_wdata = tx_buf[buf_idx];

  // Behavioural byte engine with a register-file slave behind it.
  logic [7:0] slv_mem [16];
  logic [3:0] slv_ptr;
  int         slv_phase;
  logic       mdl_busy;
  logic [2:0] e_op;
  logic [7:0] e_byte;
  int         e_cnt;
  logic [2:0] log_op [256];
  logic [7:0] log_b  [256];
  int         log_n;

  function automatic logic [7:0] slv_init(input int i);
    return 8'(8'h30 + i * 7);
  endfunction

  assign bus_busy = mdl_busy | force_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done <= 1'b0; cmd_rx <= 8'h00; mdl_busy <= 1'b0; e_cnt <= 0;
      e_op <= 3'd0; e_byte <= 8'h00; slv_ptr <= 4'd0; slv_phase <= 0; log_n <= 0;
      we_cnt <= 0;
      for (int i = 0; i < 16; i++) slv_mem[i] <= slv_init(i);
    end else begin
      cmd_done <= 1'b0;
      if (buf_we) begin
        rx_buf[buf_idx] <= buf_rdata;
        we_cnt <= we_cnt + 1;
      end
      if (cmd_valid) begin
        e_op <= cmd_op; e_byte <= cmd_byte; e_cnt <= ENG_LAT;
        log_op[log_n] <= cmd_op; log_b[log_n] <= cmd_byte; log_n <= log_n + 1;
      end else if (e_cnt != 0) begin
        e_cnt <= e_cnt - 1;
        if (e_cnt == 1) begin
          cmd_done <= 1'b1;
          case (e_op)
            C_START, C_RSTART: begin mdl_busy <= 1'b1; slv_phase <= 0; end
            C_STOP: mdl_busy <= 1'b0;
            C_WRITE: begin
              if (slv_phase == 0) slv_phase <= e_byte[0] ? 3 : 1;
              else if (slv_phase == 1) begin slv_ptr <= e_byte[3:0]; slv_phase <= 2; end
              else begin slv_mem[slv_ptr] <= e_byte; slv_ptr <= slv_ptr + 4'd1; end
            end
            C_ARM: cmd_rx <= 8'hEE;
            default: begin cmd_rx <= slv_mem[slv_ptr]; slv_ptr <= slv_ptr + 4'd1; end
          endcase
        end
      end
    end
  end

  // Bookkeeping of checks.
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [2:0] exp_op [64];
  logic [7:0] exp_b  [64];
  int         exp_n;

  task automatic exp_push(input logic [2:0] op, input logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic build_write(input logic [6:0] dev, input logic [7:0] rg, input int n);
    exp_n = 0;
    exp_push(C_START, 8'h00);
    exp_push(C_WRITE, {dev, 1'b0});
    exp_push(C_WRITE, rg);
    for (int i = 0; i < n; i++) exp_push(C_WRITE, tx_buf[i]);
    exp_push(C_STOP, 8'h00);
  endtask

  task automatic build_read(input logic [6:0] dev, input logic [7:0] rg, input int n);
    exp_n = 0;
    exp_push(C_START, 8'h00);
    exp_push(C_WRITE, {dev, 1'b0});
    exp_push(C_WRITE, rg);
    exp_push(C_RSTART, 8'h00);
    exp_push(C_WRITE, {dev, 1'b1});
    exp_push(C_ARM, 8'h00);
    for (int i = 0; i < n - 1; i++) exp_push(C_RACK, 8'h00);
    exp_push(C_RNACK, 8'h00);
    exp_push(C_STOP, 8'h00);
  endtask

  task automatic chk_seq(input int base, input string tag);
    int first_bad;
    first_bad = -1;
    for (int i = 0; i < exp_n; i++) begin
      if (first_bad < 0 && (base + i >= log_n || log_op[base+i] != exp_op[i] ||
          (exp_op[i] == C_WRITE && log_b[base+i] != exp_b[i])))
        first_bad = i;
    end
    if (first_bad < 0 && (log_n - base) != exp_n) first_bad = exp_n;
    chk(first_bad < 0, tag, first_bad < 0 ? log_n - base : first_bad, exp_n);
  endtask

  task automatic send_req(input logic rd, input logic [6:0] dev, input logic [7:0] rg,
                          input int n);
    @(negedge clk);
    req_read = rd; req_dev = dev; req_reg = rg; req_len = LW'(n); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (xact_done !== 1'b1 && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 2000, tag, k, 0);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(in_prog == 1'b0 && cmd_valid == 1'b0, "R1 idle after reset", {in_prog, cmd_valid}, 0);
    chk(fault == 2'd0 && recover_req == 1'b0 && xact_done == 1'b0 && buf_we == 1'b0,
        "R1 no fault after reset", {fault, recover_req, xact_done, buf_we}, 0);
  endtask

  task automatic t_write();
    int base;
    base = log_n;
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    build_write(7'h5A, 8'h02, 3);
    send_req(1'b0, 7'h5A, 8'h02, 3);
    chk(in_prog == 1'b1, "R8 in_prog after launch", in_prog, 1);
    // stray request while busy with the message (R8: must be ignored)
    req_read = 1'b1; req_reg = 8'h09; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    wait_done("R8 write done");
    chk(in_prog == 1'b0, "R8 in_prog cleared at done", in_prog, 0);
    chk(fault == 2'd0, "R2 write fault code", fault, 0);
    chk_seq(base, "R2 write command chain");
    @(negedge clk);
    chk(log_n == base + exp_n, "R8 stray request ignored", log_n - base, exp_n);
    chk(slv_mem[2] == 8'hA1 && slv_mem[3] == 8'hB2 && slv_mem[4] == 8'hC3,
        "R2 slave registers written", {slv_mem[2], slv_mem[3], slv_mem[4]}, 24'hA1B2C3);
  endtask

  task automatic t_write_zero();
    int base;
    base = log_n;
    build_write(7'h21, 8'h07, 0);
    send_req(1'b0, 7'h21, 8'h07, 0);
    wait_done("R3 zero write done");
    chk_seq(base, "R3 zero-count write chain");
  endtask

  task automatic t_read();
    int base, wb;
    base = log_n; wb = we_cnt;
    build_read(7'h5A, 8'h08, 4);
    send_req(1'b1, 7'h5A, 8'h08, 4);
    wait_done("R4 read done");
    chk_seq(base, "R4 read command chain");
    @(negedge clk);
    chk(we_cnt - wb == 4, "R5 dummy not stored", we_cnt - wb, 4);
    for (int i = 0; i < 4; i++)
      chk(rx_buf[i] == slv_init(8 + i), "R5 read byte order", rx_buf[i], slv_init(8 + i));
  endtask

  task automatic t_read_zero();
    int base, wb;
    base = log_n; wb = we_cnt;
    build_read(7'h33, 8'h0C, 1);
    send_req(1'b1, 7'h33, 8'h0C, 0);
    wait_done("R6 zero read done");
    chk_seq(base, "R6 zero-count read chain");
    @(negedge clk);
    chk(we_cnt - wb == 1 && rx_buf[0] == slv_init(12), "R6 single byte stored",
        rx_buf[0], slv_init(12));
  endtask

  task automatic t_busy_wait();
    int base;
    base = log_n;
    tx_buf[0] = 8'h5C;
    build_write(7'h44, 8'h0E, 1);
    @(negedge clk);
    force_busy = 1'b1;
    send_req(1'b0, 7'h44, 8'h0E, 1);
    chk(fault == 2'd1, "R9 busy code", fault, 1);
    repeat (5) @(negedge clk);
    chk(log_n == base && in_prog == 1'b0, "R9 no command while busy", log_n - base, 0);
    force_busy = 1'b0;
    wait_done("R9 launch after bus free");
    chk_seq(base, "R9 chain after wait");
    chk(slv_mem[14] == 8'h5C, "R9 data delivered", slv_mem[14], 8'h5C);
  endtask

  task automatic t_timeout_retry();
    int base;
    base = log_n;
    build_read(7'h5A, 8'h01, 2);
    @(negedge clk);
    force_busy = 1'b1;
    send_req(1'b1, 7'h5A, 8'h01, 2);
    repeat (TOUT - 1) @(negedge clk);
    chk(fault == 2'd1 && recover_req == 1'b0, "R10 still busy before window", fault, 1);
    @(negedge clk);
    chk(fault == 2'd2 && recover_req == 1'b1, "R10 timeout code", fault, 2);
    repeat (6) @(negedge clk);
    chk(recover_req == 1'b1 && log_n == base, "R10 recovery held", recover_req, 1);
    force_busy = 1'b0; recover_done = 1'b1;
    @(negedge clk);
    recover_done = 1'b0;
    wait_done("R10 retry done");
    chk_seq(base, "R10 retry chain");
    chk(fault == 2'd2, "R10 retry keeps timeout code", fault, 2);
  endtask

  task automatic t_permanent();
    int base, k;
    base = log_n;
    @(negedge clk);
    force_busy = 1'b1;
    send_req(1'b0, 7'h12, 8'h03, 2);
    k = 0;
    while (recover_req !== 1'b1 && k < 500) begin @(negedge clk); k++; end
    chk(k < 500, "R10 recovery requested", k, 0);
    recover_done = 1'b1;
    @(negedge clk);
    recover_done = 1'b0;
    wait_done("R11 permanent done");
    chk(fault == 2'd3 && in_prog == 1'b0, "R11 permanent code", fault, 3);
    chk(log_n == base, "R11 no command issued", log_n - base, 0);
    @(negedge clk);
    chk(recover_req == 1'b0 && xact_done == 1'b0, "R11 back to idle", recover_req, 0);
    force_busy = 1'b0;
  endtask

  // R7 one outstanding command: also covered by the chains above.
  initial begin
    for (int i = 0; i < 16; i++) tx_buf[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_write_zero();
    t_read();
    t_read_zero();
    t_busy_wait();
    t_timeout_retry();
    t_permanent();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule